// File: doc/BRIEF.md
# Wait-State Bus Slave for a 12-bit Analog Input Module

This block is the peripheral side of a simple 16-bit module bus running at 8 MHz. It watches two select strobes. The first opens an I/O space that holds a control register, a conversion-start address and the converter result. The second opens a 32-byte identification space. Each access ends with a single-cycle acknowledge. The number of wait states in front of that acknowledge depends on the kind of access. A read of the result is stretched for as long as a conversion is still running.

The converter is modelled as a busy flag and a down-counter of 68 clocks (8.5 µs at 8 MHz). When the count runs out, the counter loads the sample presented on `sample_i` into the result register and clears busy. A conversion can be started in two ways: by a bus write to the start address, or by a rising edge on an asynchronous trigger pin, which is first passed through a two-flop synchronizer.

Top module: `adc_bus_slave`

## Requirements
- R1: While `id_sel_i` is high, a read of address `a` (0..31) completes with 0 wait states. It returns `8'h5A ^ ((a*37) mod 256)` on `rdata_o[7:0]`, and `rdata_o[15:8]` is 0.
- R2: I/O address 0 is the control register. After reset it reads 0, and afterwards it reads the last value written. A read completes with 0 wait states.
- R3: A write to I/O address 0 completes with exactly 1 wait state.
- R4: A write to I/O address 2 completes with 0 wait states. If the converter is idle, the write starts a conversion, and `busy_o` is already high in the cycle that carries the acknowledge.
- R5: Once started, `busy_o` stays high for exactly 68 clocks. After that, a read of I/O address 1 returns `{sample_i, 4'b0000}`, where `sample_i` is the value present on the clock edge that ends the conversion.
- R6: A read of I/O address 1 while the converter is idle completes with exactly 3 wait states.
- R7: A read of I/O address 1 that arrives during a conversion is not acknowledged while `busy_o` is high. Issued three clocks after the start, it completes with 66 wait states.
- R8: `trig_i` is synchronized. Its rising edge makes `busy_o` high on the third clock edge after the change. Holding `trig_i` high does not start another conversion.
- R9: A start write or a trigger edge that arrives while `busy_o` is high is ignored: it does not lengthen the 68-clock busy period.
- R10: `ack_o` is a one-cycle pulse. It is high only while a select strobe is high, and each select period gets at most one acknowledge.
- R11: I/O addresses 3..31 complete with 0 wait states. A read from them returns 0, and a write to them changes nothing that the control register read shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 8 MHz bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_sel_i | input | 1 | I/O space select, held until acknowledge |
| id_sel_i | input | 1 | Identification space select, held until acknowledge |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address within the selected space |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while `ack_o` is high |
| ack_o | output | 1 | Access acknowledge pulse |
| trig_i | input | 1 | Asynchronous external conversion trigger |
| sample_i | input | 12 | Converter sample taken when a conversion ends |
| busy_o | output | 1 | Conversion in progress |

## Verification
The assertions assume that the two select strobes are never high together. They also assume that the master keeps a strobe, its address and its write flag steady until the acknowledge, and drops the strobe for at least one clock edge afterwards. Every bus access in the bench comes from one task that follows this order, and `sample_i` changes only while the converter is idle. The random phase mixes register, identification and unmapped accesses. Directed sequences cover the stretched read, starts that are ignored while busy, and a trigger level held high.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [2:0] {
    CY_IDLE, CY_ID, CY_CTRL_RD, CY_CTRL_WR, CY_CONV, CY_RES, CY_MISC_RD, CY_MISC_WR
  } cyc_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_RES  = 1;
  localparam int ADR_CONV = 2;
  localparam logic [7:0] ID_SEED = 8'h5A;
  localparam int ID_MULT = 37;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q & ~s3_q;

  // R8
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
  parameter int ADC_W    = 12,
  parameter int CONV_CYC = 68
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ADC_W-1:0] sample_i,
  output logic             busy_o,
  output logic [ADC_W-1:0] result_o
);
  localparam int CW = $clog2(CONV_CYC);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      result_o <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q   <= 1'b0;
        result_o <= sample_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CONV_CYC - 1);
    end
  end

  assign busy_o = busy_q;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5
  result_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> result_o == $past(sample_i));
endmodule

// File: rtl/adc_wait_ctrl.sv
module adc_wait_ctrl #(
  parameter int WS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic [WS_W-1:0] need_i,
  input  logic            ready_i,
  output logic            fire_o,
  output logic            ack_o
);
  logic [WS_W-1:0] cnt_q;
  logic            done_q;

  // access completes on this edge
  assign fire_o = sel_i & ~done_q & (cnt_q == need_i) & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      ack_o  <= fire_o;
      done_q <= sel_i & (done_q | fire_o);
      if (!sel_i || fire_o)   cnt_q <= '0;
      else if (cnt_q != need_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  ack_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> sel_i);

  // R10
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/adc_bus_slave.sv
module adc_bus_slave
  import adc_bus_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int ADC_W      = 12,
  parameter int CONV_CYC   = 68,
  parameter int WS_CTRL_WR = 1,
  parameter int WS_RESULT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic              id_sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  input  logic              trig_i,
  input  logic [ADC_W-1:0]  sample_i,
  output logic              busy_o
);
  localparam int WS_MAX = (WS_RESULT > WS_CTRL_WR) ? WS_RESULT : WS_CTRL_WR;
  localparam int WS_W   = $clog2(WS_MAX + 1);
  localparam int PAD_W  = DATA_W - ADC_W;

  cyc_e             cyc;
  logic [WS_W-1:0]  need;
  logic             ready, fire, trig_edge, conv_start;
  logic [ADC_W-1:0] result;
  logic [7:0]       id_byte;
  logic [DATA_W-1:0] ctrl_q, rd_mux;

  always_comb begin
    cyc = CY_IDLE;
    if (id_sel_i) cyc = CY_ID;
    else if (io_sel_i) begin
      if (addr_i == ADDR_W'(ADR_CTRL))      cyc = wr_i ? CY_CTRL_WR : CY_CTRL_RD;
      else if (addr_i == ADDR_W'(ADR_RES))  cyc = wr_i ? CY_MISC_WR : CY_RES;
      else if (addr_i == ADDR_W'(ADR_CONV)) cyc = wr_i ? CY_CONV : CY_MISC_RD;
      else                                  cyc = wr_i ? CY_MISC_WR : CY_MISC_RD;
    end
  end

  always_comb begin
    case (cyc)
      CY_CTRL_WR: need = WS_W'(WS_CTRL_WR);
      CY_RES:     need = WS_W'(WS_RESULT);
      default:    need = '0;
    endcase
  end

  assign ready = (cyc != CY_RES) | ~busy_o;

  // identification table computed from the address
  assign id_byte = ID_SEED ^ 8'(int'(addr_i) * ID_MULT);

  always_comb begin
    case (cyc)
      CY_ID:      rd_mux = {{(DATA_W-8){1'b0}}, id_byte};
      CY_CTRL_RD: rd_mux = ctrl_q;
      CY_RES:     rd_mux = {result, {PAD_W{1'b0}}};
      default:    rd_mux = '0;
    endcase
  end

  adc_wait_ctrl #(.WS_W(WS_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (io_sel_i | id_sel_i),
    .need_i  (need),
    .ready_i (ready),
    .fire_o  (fire),
    .ack_o   (ack_o)
  );

  adc_trig_sync u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  assign conv_start = (fire & (cyc == CY_CONV)) | trig_edge;

  adc_conv_model #(.ADC_W(ADC_W), .CONV_CYC(CONV_CYC)) u_conv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (conv_start),
    .sample_i (sample_i),
    .busy_o   (busy_o),
    .result_o (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rdata_o <= '0;
    end else if (fire) begin
      rdata_o <= rd_mux;
      if (cyc == CY_CTRL_WR) ctrl_q <= wdata_i;
    end
  end

  // R7
  no_res_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cyc == CY_RES) |-> !busy_o);

  // R4
  conv_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cyc == CY_CONV && !busy_o) |=> busy_o);
endmodule

// File: tb/adc_bus_slave_test.sv
`timescale 1ns/1ps
module adc_bus_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sel = 1'b0, id_sel = 1'b0, wr = 1'b0, trig = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [11:0] sample = '0;
  logic [15:0] rdata;
  logic        ack, busy;

  int checks = 0, errors = 0;
  int run_len = 0, last_len = 0;
  logic [15:0] ctrl_model = '0;

  always #4 clk = ~clk;

  adc_bus_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .io_sel_i(io_sel), .id_sel_i(id_sel),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .trig_i(trig), .sample_i(sample), .busy_o(busy)
  );

  // busy run length monitor
  always @(negedge clk) begin
    if (busy) run_len <= run_len + 1;
    else begin
      if (run_len != 0) last_len <= run_len;
      run_len <= 0;
    end
  end

  function automatic logic [7:0] exp_id(input int a);
    return 8'h5A ^ 8'((a * 37) % 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic id, input logic w, input logic [4:0] a,
                     input logic [15:0] d, output logic [15:0] rd, output int waits);
    @(negedge clk);
    id_sel = id; io_sel = ~id; wr = w; addr = a; wdata = d;
    waits = 0;
    forever begin
      @(negedge clk);
      if (ack) break;
      waits++;
      if (waits > 500) break;
    end
    rd = rdata;
    @(negedge clk);
    id_sel = 1'b0; io_sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] rd;
    int w;
    logic [11:0] smp;
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    check("R2 reset ack", int'(ack), 0);
    check("R4 reset busy", int'(busy), 0);
    rst_n = 1'b1;

    bus(1'b0, 1'b0, 5'd0, 16'h0, rd, w);
    check("R2 ctrl reset value", int'(rd), 0);
    check("R2 ctrl read waits", w, 0);

    bus(1'b0, 1'b1, 5'd0, 16'hBEEF, rd, w);
    ctrl_model = 16'hBEEF;
    check("R3 ctrl write waits", w, 1);
    bus(1'b0, 1'b0, 5'd0, 16'h0, rd, w);
    check("R2 ctrl readback", int'(rd), int'(ctrl_model));

    // idle result read before any conversion
    bus(1'b0, 1'b0, 5'd1, 16'h0, rd, w);
    check("R6 idle result waits", w, 3);
    check("R6 initial result", int'(rd), 0);

    // random mix
    for (int i = 0; i < 120; i++) begin
      int kind = int'($urandom_range(0, 4));
      logic [4:0] a = 5'($urandom_range(0, 31));
      logic [15:0] d = 16'($urandom);
      case (kind)
        0: begin
          bus(1'b1, 1'b0, a, 16'h0, rd, w);
          check("R1 id data", int'(rd), int'(exp_id(int'(a))));
          check("R1 id waits", w, 0);
        end
        1: begin
          bus(1'b0, 1'b1, 5'd0, d, rd, w);
          ctrl_model = d;
          check("R3 ctrl write waits", w, 1);
        end
        2: begin
          bus(1'b0, 1'b0, 5'd0, 16'h0, rd, w);
          check("R2 ctrl read", int'(rd), int'(ctrl_model));
          check("R2 ctrl read waits", w, 0);
        end
        3: begin
          if (a < 5'd3) a = 5'd3 + 5'($urandom_range(0, 28));
          bus(1'b0, 1'b0, a, 16'h0, rd, w);
          check("R11 unmapped read data", int'(rd), 0);
          check("R11 unmapped read waits", w, 0);
        end
        default: begin
          if (a < 5'd3) a = 5'd31;
          bus(1'b0, 1'b1, a, d, rd, w);
          check("R11 unmapped write waits", w, 0);
          bus(1'b0, 1'b0, 5'd0, 16'h0, rd, w);
          check("R11 ctrl unaffected", int'(rd), int'(ctrl_model));
        end
      endcase
    end

    // conversion by write, then immediate stretched read
    smp = 12'hA53;
    sample = smp;
    bus(1'b0, 1'b1, 5'd2, 16'h0, rd, w);
    check("R4 conv write waits", w, 0);
    check("R4 busy after start", int'(busy), 1);
    bus(1'b0, 1'b0, 5'd1, 16'h0, rd, w);
    check("R7 stretched read waits", w, 66);
    check("R5 result word", int'(rd), int'({smp, 4'b0}));
    wait_idle();
    check("R5 busy length", last_len, 68);
    bus(1'b0, 1'b0, 5'd1, 16'h0, rd, w);
    check("R6 idle result waits", w, 3);

    // several conversions with random samples
    for (int k = 0; k < 4; k++) begin
      smp = 12'($urandom);
      sample = smp;
      bus(1'b0, 1'b1, 5'd2, 16'h0, rd, w);
      wait_idle();
      bus(1'b0, 1'b0, 5'd1, 16'h0, rd, w);
      check("R5 random result", int'(rd), int'({smp, 4'b0}));
      check("R5 busy length", last_len, 68);
    end

    // requests while busy are ignored
    sample = 12'h3C1;
    bus(1'b0, 1'b1, 5'd2, 16'h0, rd, w);
    repeat (10) @(negedge clk);
    bus(1'b0, 1'b1, 5'd2, 16'h0, rd, w);
    check("R9 conv write while busy waits", w, 0);
    trig = 1'b1;
    repeat (4) @(negedge clk);
    trig = 1'b0;
    wait_idle();
    check("R9 busy not extended", last_len, 68);
    repeat (3) @(negedge clk);
    check("R9 no late start", int'(busy), 0);

    // external trigger held high
    smp = 12'h5E7;
    sample = smp;
    trig = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 not yet busy", int'(busy), 0);
    @(negedge clk);
    check("R8 busy on third edge", int'(busy), 1);
    wait_idle();
    check("R8 trigger busy length", last_len, 68);
    repeat (5) @(negedge clk);
    check("R8 held level no restart", int'(busy), 0);
    trig = 1'b0;
    bus(1'b0, 1'b0, 5'd1, 16'h0, rd, w);
    check("R5 trigger result", int'(rd), int'({smp, 4'b0}));

    // R10 ack low after access ends
    @(negedge clk);
    check("R10 ack idle", int'(ack), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule